// File: doc/BRIEF.md
# Interrupt Entry and Stack Sequencer

This block sequences the stack traffic of an 8-bit processor with a 16-bit address space. It owns the program counter, the stack pointer and the status byte. It performs the memory cycles for four kinds of entry: maskable interrupt, non-maskable interrupt, software break and reset. It also performs the two stack returns, return-from-interrupt and return-from-subroutine. A byte-wide synchronous memory port carries the traffic. Read data comes back one clock after the address is presented.

Instruction decode, the ALU and the addressing modes live elsewhere. The surrounding core raises a request line, watches `busy`, and takes the new program counter when `done` pulses. The maskable request is a level and is gated by the interrupt-disable flag. The non-maskable request is edge-captured, so one rising edge gives exactly one entry. It wins over a simultaneous maskable request. While a sequence runs, new requests other than a captured non-maskable edge are dropped. A running counter adds the entry cost of seven cycles for every interrupt or break entry.

Status bits used: bit 2 is interrupt-disable, bit 4 is break and bit 5 is the always-one bit.

Top module: `int_stack_seq`

## Requirements
- R1: After reset, pcOut equals START_PC (default 0x8000), spOut is 0xFF, statusOut is 0x30, cycleCount is 0, and busy and done are low.
- R2: A maskable entry (irqLevel high, status bit 2 clear) writes PC high byte at 0x0100+SP, PC low byte at the next lower stack address, then the status byte with bit 4 cleared and bit 5 set. It leaves SP three lower, loads PC from 0xFFFE (low byte) and 0xFFFF (high byte), sets status bit 2 and clears status bit 4.
- R3: While status bit 2 is set, a high irqLevel starts no sequence: busy stays low, no memory write occurs and pcOut is unchanged.
- R4: A rising edge on nmiReq causes one entry through vector 0xFFFA/0xFFFB with the same push order as R2. It is taken even when status bit 2 is set. Holding nmiReq high causes no second entry.
- R5: When an nmiReq edge and an unmasked irqLevel arrive in the same cycle, the non-maskable entry is taken first, and the maskable request is then masked by the bit 2 it sets.
- R6: A break request pushes PC+2 (high byte first), then the status byte with bits 4 and 5 set. It loads PC from 0xFFFE/0xFFFF and leaves status bits 2 and 4 set.
- R7: A return-from-interrupt pops the status byte (bits 4 and 5 forced to 1), then the PC low byte, then the PC high byte, leaving SP three higher.
- R8: A return-from-subroutine pops the PC low byte, then the high byte, sets PC to that word plus 1, leaves SP two higher and leaves status unchanged.
- R9: Every memory write goes to page 0x01 at 0x0100+SP and decrements SP afterwards. A pop increments SP first. SP wraps modulo 256 in both directions.
- R10: busy is high for 6 cycles for an entry, 4 for a return-from-interrupt and 3 for a return-from-subroutine. done then pulses for one cycle with busy low. A break, return or maskable request presented while busy is dropped.
- R11: cycleCount rises by exactly 7 at the end of each interrupt or break entry and never changes otherwise.
- R12: Status bit 5 reads 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqLevel | input | 1 | Maskable interrupt request level |
| nmiReq | input | 1 | Non-maskable request, rising-edge captured |
| brkReq | input | 1 | Software break request, sampled while idle |
| rtiReq | input | 1 | Return-from-interrupt request, sampled while idle |
| rtsReq | input | 1 | Return-from-subroutine request, sampled while idle |
| memAddr | output | 16 | Memory address |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Memory write enable |
| memRdata | input | 8 | Memory read data, one cycle after the address |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle pulse when a sequence has finished |
| pcOut | output | 16 | Program counter |
| spOut | output | 8 | Stack pointer |
| statusOut | output | 8 | Status byte |
| cycleCount | output | 32 | Running count of entry cycles |

## Verification
Some properties are checked on every cycle:
- every write lands on the stack page and is followed by a one-step SP decrement, with wrap;
- SP holds still across idle cycles;
- done is a single pulse outside busy;
- no sequence stays busy longer than six cycles;
- the counter moves only by seven and only with done;
- status bit 5 is never cleared.

Other behaviour shows only in the bench's scenarios:
- the byte order and values on the stack for each cause;
- vector selection;
- the break bit in the pushed status;
- masking, edge capture and priority;
- dropping of requests while busy;
- the popped PC and status values.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int CYC_W = 32;
  localparam int MAX_BUSY = 6;

  localparam int FLAG_I = 2;
  localparam int FLAG_B = 4;
  localparam int FLAG_U = 5;

  typedef enum logic [2:0] {
    CAUSE_NMI, CAUSE_IRQ, CAUSE_BRK, CAUSE_RTI, CAUSE_RTS
  } cause_e;

  typedef enum logic [1:0] {
    ADR_PUSH, ADR_POP, ADR_VLO, ADR_VHI
  } adrSel_e;

  typedef enum logic [1:0] {
    WR_PCH, WR_PCL, WR_ST
  } wrSel_e;

  typedef struct packed {
    cause_e  cause;
    adrSel_e adrSel;
    wrSel_e  wrSel;
    logic    memWe;
    logic    spDec;
    logic    spInc;
    logic    enterSt;
    logic    loadSt;
    logic    loadLo;
    logic    loadPc;
    logic    pcSkip;
    logic    addCyc;
  } strobe_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    irqLevel,
  input  logic    nmiReq,
  input  logic    brkReq,
  input  logic    rtiReq,
  input  logic    rtsReq,
  input  logic    statusI,
  output strobe_t strobe,
  output logic    busy,
  output logic    done
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_PUSH_HI, ST_PUSH_LO, ST_PUSH_ST, ST_VEC_LO, ST_VEC_HI,
    ST_VEC_END, ST_POP_ST, ST_POP_LO, ST_POP_HI, ST_POP_END
  } state_e;

  state_e state, stateNext;
  cause_e cause, causeNext;
  logic   nmiPrev, nmiPend, acceptNmi;
  logic   nmiRise, nmiWant;

  assign nmiRise = nmiReq & ~nmiPrev;
  assign nmiWant = nmiPend | nmiRise;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strobe       = '0;
    strobe.cause = cause;
    stateNext    = state;
    causeNext    = cause;
    acceptNmi    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (nmiWant) begin
          causeNext = CAUSE_NMI;
          acceptNmi = 1'b1;
          stateNext = ST_PUSH_HI;
        end else if (irqLevel && !statusI) begin
          causeNext = CAUSE_IRQ;
          stateNext = ST_PUSH_HI;
        end else if (brkReq) begin
          causeNext     = CAUSE_BRK;
          strobe.pcSkip = 1'b1;
          stateNext     = ST_PUSH_HI;
        end else if (rtiReq) begin
          causeNext = CAUSE_RTI;
          stateNext = ST_POP_ST;
        end else if (rtsReq) begin
          causeNext = CAUSE_RTS;
          stateNext = ST_POP_LO;
        end
      end
      ST_PUSH_HI: begin
        strobe.adrSel = ADR_PUSH;
        strobe.wrSel  = WR_PCH;
        strobe.memWe  = 1'b1;
        strobe.spDec  = 1'b1;
        stateNext     = ST_PUSH_LO;
      end
      ST_PUSH_LO: begin
        strobe.adrSel = ADR_PUSH;
        strobe.wrSel  = WR_PCL;
        strobe.memWe  = 1'b1;
        strobe.spDec  = 1'b1;
        stateNext     = ST_PUSH_ST;
      end
      ST_PUSH_ST: begin
        strobe.adrSel  = ADR_PUSH;
        strobe.wrSel   = WR_ST;
        strobe.memWe   = 1'b1;
        strobe.spDec   = 1'b1;
        strobe.enterSt = 1'b1;
        stateNext      = ST_VEC_LO;
      end
      ST_VEC_LO: begin
        strobe.adrSel = ADR_VLO;
        stateNext     = ST_VEC_HI;
      end
      ST_VEC_HI: begin
        strobe.adrSel = ADR_VHI;
        strobe.loadLo = 1'b1;
        stateNext     = ST_VEC_END;
      end
      ST_VEC_END: begin
        strobe.loadPc = 1'b1;
        strobe.addCyc = 1'b1;
        stateNext     = ST_IDLE;
      end
      ST_POP_ST: begin
        strobe.adrSel = ADR_POP;
        strobe.spInc  = 1'b1;
        stateNext     = ST_POP_LO;
      end
      ST_POP_LO: begin
        strobe.adrSel = ADR_POP;
        strobe.spInc  = 1'b1;
        strobe.loadSt = (cause == CAUSE_RTI);
        stateNext     = ST_POP_HI;
      end
      ST_POP_HI: begin
        strobe.adrSel = ADR_POP;
        strobe.spInc  = 1'b1;
        strobe.loadLo = 1'b1;
        stateNext     = ST_POP_END;
      end
      ST_POP_END: begin
        strobe.loadPc = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cause   <= CAUSE_IRQ;
      nmiPrev <= 1'b0;
      nmiPend <= 1'b0;
      done    <= 1'b0;
    end else begin
      state   <= stateNext;
      cause   <= causeNext;
      nmiPrev <= nmiReq;
      nmiPend <= nmiWant & ~acceptNmi;
      done    <= (state == ST_VEC_END) || (state == ST_POP_END);
    end
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter logic [AW-1:0] START_PC     = 16'h8000,
  parameter logic [AW-1:0] NMI_VEC      = 16'hFFFA,
  parameter logic [AW-1:0] IRQ_VEC      = 16'hFFFE,
  parameter logic [DW-1:0] STACK_PAGE   = 8'h01,
  parameter int            ENTRY_CYCLES = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [DW-1:0]    memRdata,
  output logic [AW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  output logic             memWe,
  output logic [AW-1:0]    pc,
  output logic [DW-1:0]    sp,
  output logic [DW-1:0]    st,
  output logic [CYC_W-1:0] cyc
);
  localparam logic [DW-1:0] MASK_B = DW'(1) << FLAG_B;
  localparam logic [DW-1:0] MASK_U = DW'(1) << FLAG_U;
  localparam logic [DW-1:0] MASK_I = DW'(1) << FLAG_I;

  logic [DW-1:0] lo;
  logic [DW-1:0] spNext;
  logic [DW-1:0] entryBase;
  logic [AW-1:0] vec;
  logic          isBrk, isRts;

  assign isBrk     = (strobe.cause == CAUSE_BRK);
  assign isRts     = (strobe.cause == CAUSE_RTS);
  assign spNext    = sp + DW'(1);
  assign vec       = (strobe.cause == CAUSE_NMI) ? NMI_VEC : IRQ_VEC;
  assign entryBase = isBrk ? (st | MASK_B) : (st & ~MASK_B);
  assign memWe     = strobe.memWe;

  always_comb begin
    case (strobe.adrSel)
      ADR_PUSH: memAddr = {STACK_PAGE, sp};
      ADR_POP:  memAddr = {STACK_PAGE, spNext};
      ADR_VLO:  memAddr = vec;
      default:  memAddr = vec + AW'(1);
    endcase
    case (strobe.wrSel)
      WR_PCH:  memWdata = pc[AW-1:DW];
      WR_PCL:  memWdata = pc[DW-1:0];
      default: memWdata = entryBase | MASK_U;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc  <= START_PC;
      sp  <= '1;
      st  <= MASK_B | MASK_U;
      lo  <= '0;
      cyc <= '0;
    end else begin
      if (strobe.pcSkip)
        pc <= pc + AW'(2);
      else if (strobe.loadPc)
        pc <= {memRdata, lo} + AW'(isRts);
      if (strobe.spDec)
        sp <= sp - DW'(1);
      else if (strobe.spInc)
        sp <= spNext;
      if (strobe.enterSt)
        st <= entryBase | MASK_I;
      else if (strobe.loadSt)
        st <= memRdata | MASK_B | MASK_U;
      if (strobe.loadLo)
        lo <= memRdata;
      if (strobe.addCyc)
        cyc <= cyc + CYC_W'(ENTRY_CYCLES);
    end
  end
endmodule

// File: rtl/int_stack_seq.sv
module int_stack_seq
  import seq_pkg::*;
#(
  parameter logic [AW-1:0] START_PC     = 16'h8000,
  parameter logic [AW-1:0] NMI_VEC      = 16'hFFFA,
  parameter logic [AW-1:0] IRQ_VEC      = 16'hFFFE,
  parameter logic [DW-1:0] STACK_PAGE   = 8'h01,
  parameter int            ENTRY_CYCLES = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irqLevel,
  input  logic             nmiReq,
  input  logic             brkReq,
  input  logic             rtiReq,
  input  logic             rtsReq,
  output logic [AW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  output logic             memWe,
  input  logic [DW-1:0]    memRdata,
  output logic             busy,
  output logic             done,
  output logic [AW-1:0]    pcOut,
  output logic [DW-1:0]    spOut,
  output logic [DW-1:0]    statusOut,
  output logic [CYC_W-1:0] cycleCount
);
  strobe_t strobe;

  seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .irqLevel (irqLevel),
    .nmiReq   (nmiReq),
    .brkReq   (brkReq),
    .rtiReq   (rtiReq),
    .rtsReq   (rtsReq),
    .statusI  (statusOut[FLAG_I]),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  seq_datapath #(
    .START_PC     (START_PC),
    .NMI_VEC      (NMI_VEC),
    .IRQ_VEC      (IRQ_VEC),
    .STACK_PAGE   (STACK_PAGE),
    .ENTRY_CYCLES (ENTRY_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .pc       (pcOut),
    .sp       (spOut),
    .st       (statusOut),
    .cyc      (cycleCount)
  );
endmodule

// File: rtl/int_stack_seq_chk.sv
module int_stack_seq_chk
  import seq_pkg::*;
#(
  parameter logic [DW-1:0] STACK_PAGE   = 8'h01,
  parameter int            ENTRY_CYCLES = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic [DW-1:0]    stackHi,
  input logic             memWe,
  input logic             busy,
  input logic             done,
  input logic [DW-1:0]    spOut,
  input logic             unusedBit,
  input logic [CYC_W-1:0] cycleCount
);
  logic [3:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else if (!busy) runLen <= '0;
    else if (runLen != 4'hF) runLen <= runLen + 4'd1;
  end

  // R9: writes only hit the stack page
  p_stack_page_r9: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> stackHi == STACK_PAGE);

  // R9: each write is followed by a one-step SP decrement (mod 256)
  p_push_dec_r9: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> spOut == $past(spOut) - 8'd1);

  // R10: SP does not move across an idle cycle
  p_sp_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(spOut));

  // R10: done only outside busy, and only for one cycle
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: no sequence is busy longer than an entry
  p_busy_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> runLen < 4'(MAX_BUSY));

  // R11: counter moves only with done and only by the entry cost
  p_cycle_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cycleCount) |-> (done && cycleCount == $past(cycleCount) + CYC_W'(ENTRY_CYCLES)));

  // R12: status bit 5 always set
  p_unused_set_r12: assert property (@(posedge clk) disable iff (!rstN)
    unusedBit);
endmodule

bind int_stack_seq int_stack_seq_chk #(
  .STACK_PAGE   (STACK_PAGE),
  .ENTRY_CYCLES (ENTRY_CYCLES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .stackHi    (memAddr[15:8]),
  .memWe      (memWe),
  .busy       (busy),
  .done       (done),
  .spOut      (spOut),
  .unusedBit  (statusOut[5]),
  .cycleCount (cycleCount)
);

// File: tb/int_stack_seq_bench.sv
module int_stack_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irqLevel = 1'b0, nmiReq = 1'b0, brkReq = 1'b0, rtiReq = 1'b0, rtsReq = 1'b0;
  logic [15:0] memAddr;
  logic [7:0]  memWdata, memRdata;
  logic        memWe, busy, done;
  logic [15:0] pcOut;
  logic [7:0]  spOut, statusOut;
  logic [31:0] cycleCount;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  int_stack_seq u_int_stack_seq (
    .clk(clk), .rstN(rstN), .irqLevel(irqLevel), .nmiReq(nmiReq),
    .brkReq(brkReq), .rtiReq(rtiReq), .rtsReq(rtsReq),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRdata(memRdata),
    .busy(busy), .done(done), .pcOut(pcOut), .spOut(spOut),
    .statusOut(statusOut), .cycleCount(cycleCount)
  );

  // synchronous RAM model, 4 KiB aliased over the address space
  logic [7:0]  ram [0:4095];
  logic        tbWe = 1'b0;
  logic [11:0] tbA = '0;
  logic [7:0]  tbD = '0;
  always @(posedge clk) begin
    if (tbWe) ram[tbA] <= tbD;
    else if (memWe) ram[memAddr[11:0]] <= memWdata;
    memRdata <= ram[memAddr[11:0]];
  end

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    tbWe = 1'b1; tbA = a[11:0]; tbD = d;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard of expected memory writes
  typedef struct {
    logic [15:0] a;
    logic [7:0]  d;
    string       tag;
  } exp_t;
  exp_t q[$];
  exp_t cur;

  task automatic expectWr(input logic [15:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    e.a = a; e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (q.size() == 0) begin
        check(1'b0, "R3 unexpected write addr", {16'h0, memAddr}, 32'h0);
      end else begin
        cur = q.pop_front();
        check(memAddr == cur.a, {cur.tag, " write address"}, {16'h0, memAddr}, {16'h0, cur.a});
        check(memWdata == cur.d, {cur.tag, " write data"}, {24'h0, memWdata}, {24'h0, cur.d});
      end
    end
  end

  // kind: 0 irq, 1 nmi, 2 brk, 3 rti, 4 rts, 5 nmi+irq together
  task automatic runSeq(input int kind, input int expBusy, input bit injectBrk, input string tag);
    int n = 0;
    bit seen = 1'b0;
    @(negedge clk);
    case (kind)
      0: irqLevel = 1'b1;
      1: nmiReq = 1'b1;
      2: brkReq = 1'b1;
      3: rtiReq = 1'b1;
      4: rtsReq = 1'b1;
      default: begin nmiReq = 1'b1; irqLevel = 1'b1; end
    endcase
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      brkReq = 1'b0; rtiReq = 1'b0; rtsReq = 1'b0;
      if (injectBrk && n == 1) brkReq = 1'b1;
      if (busy) n++;
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
    check(seen, {tag, " R10 done seen"}, {31'h0, seen}, 32'h1);
    check(n == expBusy, {tag, " R10 busy length"}, n, expBusy);
    @(negedge clk);
    check(!done, {tag, " R10 done one cycle"}, {31'h0, done}, 32'h0);
  endtask

  task automatic expectState(input logic [15:0] pcE, input logic [7:0] spE, input logic [7:0] stE,
                             input logic [31:0] cycE, input string tag);
    check(pcOut == pcE, {tag, " pc"}, {16'h0, pcOut}, {16'h0, pcE});
    check(spOut == spE, {tag, " sp"}, {24'h0, spOut}, {24'h0, spE});
    check(statusOut == stE, {tag, " status"}, {24'h0, statusOut}, {24'h0, stE});
    check(cycleCount == cycE, {tag, " R11 cycles"}, cycleCount, cycE);
    check(statusOut[5], {tag, " R12 bit5"}, {31'h0, statusOut[5]}, 32'h1);
  endtask

  task automatic idleHold(input int cycles, input logic [15:0] pcE, input string tag);
    bit ok = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (busy || pcOut != pcE) ok = 1'b0;
    end
    check(ok, {tag, " stays idle"}, {16'h0, pcOut}, {16'h0, pcE});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    poke(16'hFFFE, 8'h34);
    poke(16'hFFFF, 8'h12);
    poke(16'hFFFA, 8'h78);
    poke(16'hFFFB, 8'h56);
    poke(16'h0100, 8'hAB);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done, "R1 busy/done low", {30'h0, busy, done}, 32'h0);
    expectState(16'h8000, 8'hFF, 8'h30, 32'd0, "R1 reset");

    // R2 maskable entry
    expectWr(16'h01FF, 8'h80, "R2 pch");
    expectWr(16'h01FE, 8'h00, "R2 pcl");
    expectWr(16'h01FD, 8'h20, "R2 status");
    runSeq(0, 6, 1'b0, "R2");
    expectState(16'h1234, 8'hFC, 8'h24, 32'd7, "R2 irq entry");
    // R3 level still high but masked
    idleHold(6, 16'h1234, "R3 masked irq");
    irqLevel = 1'b0;

    // R7 return from interrupt
    runSeq(3, 4, 1'b0, "R7");
    expectState(16'h8000, 8'hFF, 8'h30, 32'd7, "R7 rti");

    // R6 break
    expectWr(16'h01FF, 8'h80, "R6 pch");
    expectWr(16'h01FE, 8'h02, "R6 pcl plus2");
    expectWr(16'h01FD, 8'h30, "R6 status");
    runSeq(2, 6, 1'b0, "R6");
    expectState(16'h1234, 8'hFC, 8'h34, 32'd14, "R6 brk");

    // R4 nmi with bit 2 set, held high
    expectWr(16'h01FC, 8'h12, "R4 pch");
    expectWr(16'h01FB, 8'h34, "R4 pcl");
    expectWr(16'h01FA, 8'h24, "R4 status");
    runSeq(1, 6, 1'b0, "R4");
    expectState(16'h5678, 8'hF9, 8'h24, 32'd21, "R4 nmi");
    idleHold(6, 16'h5678, "R4 held nmi");
    nmiReq = 1'b0;

    // R8 return from subroutine
    runSeq(4, 3, 1'b0, "R8");
    expectState(16'h3425, 8'hFB, 8'h24, 32'd21, "R8 rts");

    // R7 again to clear bit 2
    runSeq(3, 4, 1'b0, "R7b");
    expectState(16'h0230, 8'hFE, 8'h32, 32'd21, "R7 rti second");

    // R5 nmi and irq together
    expectWr(16'h01FE, 8'h02, "R5 pch");
    expectWr(16'h01FD, 8'h30, "R5 pcl");
    expectWr(16'h01FC, 8'h22, "R5 status");
    runSeq(5, 6, 1'b0, "R5");
    expectState(16'h5678, 8'hFB, 8'h26, 32'd28, "R5 nmi first");
    idleHold(6, 16'h5678, "R5 irq masked after");
    nmiReq = 1'b0;
    irqLevel = 1'b0;

    // R10 break request during busy is dropped
    runSeq(4, 3, 1'b1, "R10");
    expectState(16'h3023, 8'hFD, 8'h26, 32'd28, "R10 rts");
    idleHold(6, 16'h3023, "R10 dropped brk");
    check(spOut == 8'hFD, "R10 sp after drop", {24'h0, spOut}, 32'hFD);

    // R9 pop wraps FF -> 00
    runSeq(3, 4, 1'b0, "R9 pop");
    expectState(16'hAB80, 8'h00, 8'h32, 32'd28, "R9 pop wrap");

    // R9 push wraps 00 -> FF
    expectWr(16'h0100, 8'hAB, "R9 pch");
    expectWr(16'h01FF, 8'h80, "R9 pcl wrap");
    expectWr(16'h01FE, 8'h22, "R9 status");
    runSeq(0, 6, 1'b0, "R9 push");
    irqLevel = 1'b0;
    expectState(16'h1234, 8'hFD, 8'h26, 32'd35, "R9 push wrap");

    @(negedge clk);
    check(q.size() == 0, "R9 all writes seen", q.size(), 32'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule